// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous host and one asynchronous 4M x 16 extended-data-out DRAM. The host offers one request at a time through a valid/ready handshake. Each request carries a 22-bit word address, a write flag, two byte-lane enables and 16 bits of write data. The controller splits the word address into a row part and a column part and presents them one after the other on a shared address bus. The row goes out with the RAS falling edge and the column with the CAS falling edge. Each byte lane has its own CAS strobe. Read data comes back to the host with a one-cycle valid pulse.

After an access, the open row stays open. A later request to the same row only toggles CAS with a new column. The page closes when a request targets another row, when a refresh is due, or when RAS has been low for the configured maximum number of cycles. An interval timer raises a refresh request. The refresh is served with CAS-before-RAS ordering as soon as the current access ends, and it takes priority over host traffic. Every strobe width is a count of clock cycles set by a parameter. The row/column geometry is chosen from three options:

- 13 row bits by 9 column bits
- 12 by 10
- 11 by 11

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset and whenever no access or refresh is in progress, RAS, both CAS strobes and OE are high (inactive), WE is high and neither data lane is driven.
- R2: The row placed on the address pins when RAS falls is the upper ROW_W bits of the word address. The column placed there when CAS falls is the lower COL_W bits, zero-extended. Geometry 0, 1 and 2 select 13/9, 12/10 and 11/11 row/column bits.
- R3: Byte-enable bit 0 selects the lower lane (data bits 7:0, lower CAS) and bit 1 selects the upper lane (bits 15:8, upper CAS). A lane whose enable is 0 keeps its CAS high and is neither written nor driven.
- R4: During a read, WE stays high and OE is low only while CAS is low. The data present on the enabled lanes is returned on rd_data together with a one-cycle rd_valid pulse.
- R5: During a write, WE falls at least one cycle before CAS falls and stays low while CAS is low. The enabled lanes are driven from that first WE-low cycle onward.
- R6: A request to the row that is already open is served without a new RAS falling edge. Only the CAS strobes toggle, with the new column.
- R7: A request to a different row closes the page. RAS then stays high for at least T_RP cycles before it falls again with the new row.
- R8: A refresh drives both CAS strobes low at least one cycle before RAS falls, with WE high. One refresh is due every REF_INTERVAL clocks.
- R9: While a refresh is due, no host request is accepted. The open page is closed and the refresh runs before the next host access, so two refreshes are never further apart than REF_INTERVAL plus one maximal access.
- R10: No further page access is accepted once RAS has been low for T_RAS_MAX cycles. The page is closed instead.
- R11: A request is taken only in a cycle where req_valid and req_ready are both high. Each accepted read produces exactly one rd_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit 0 lower, bit 1 upper |
| req_addr | input | 22 | Word address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 2 | Per-lane drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The properties assume that every timing parameter is at least one cycle. They also assume that the host holds a request unchanged from the moment req_valid rises until the cycle in which it is taken. The bench drives each request on a falling clock edge and keeps it steady until it sees req_ready. It then withdraws the request on the next falling edge. The memory model answers reads only while CAS and OE are both low, so returned data depends only on the strobe behaviour.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    localparam int WORD_AW = 22;
    localparam int DATA_W  = 16;
    localparam int LANES   = 2;

    // geometry 0: 13/9, 1: 12/10, 2: 11/11 row/column bits
    function automatic int row_w(input int geom);
        return 13 - geom;
    endfunction

    function automatic int col_w(input int geom);
        return 9 + geom;
    endfunction

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PAGE,
        ST_PRE,
        ST_RCAS,
        ST_RREF
    } seq_state_t;

    typedef struct packed {
        logic                 we;
        logic [LANES-1:0]     be;
        logic [WORD_AW-1:0]   addr;
        logic [DATA_W-1:0]    wdata;
    } host_req_t;

    function automatic logic row_open(input seq_state_t s);
        return (s == ST_RAS) || (s == ST_COL) || (s == ST_CAS) || (s == ST_PAGE);
    endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int INTERVAL = 780,
    localparam int TW = $clog2(INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pend
);
    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = (tcnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
            pend <= 1'b0;
        end else begin
            tcnt <= tick ? '0 : tcnt + TW'(1);
            pend <= (pend && !ack) || tick;
        end
    end
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux
    import edo_ctrl_pkg::*;
#(
    parameter int GEOM = 0,
    localparam int ROW_W = row_w(GEOM),
    localparam int COL_W = col_w(GEOM)
) (
    input  logic [WORD_AW-1:0] open_addr,
    input  logic [ROW_W-1:0]   next_row,
    input  logic               sel_col,
    output logic [ROW_W-1:0]   pin_addr,
    output logic               row_hit
);
    logic [ROW_W-1:0] col_pad;
    logic [ROW_W-1:0] open_row;

    generate
        if (COL_W == ROW_W) begin : g_same
            assign col_pad = open_addr[COL_W-1:0];
        end else begin : g_pad
            assign col_pad = {{(ROW_W - COL_W){1'b0}}, open_addr[COL_W-1:0]};
        end
    endgenerate

    assign open_row = open_addr[WORD_AW-1:COL_W];
    assign pin_addr = sel_col ? col_pad : open_row;
    assign row_hit  = (next_row == open_row);
endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_ctrl_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 2,
    parameter int T_REF_RAS = 3,
    parameter int T_RAS_MAX = 40,
    localparam int TMAX = (T_RCD > T_CAS ? T_RCD : T_CAS) > (T_RP > T_REF_RAS ? T_RP : T_REF_RAS)
                        ? (T_RCD > T_CAS ? T_RCD : T_CAS) : (T_RP > T_REF_RAS ? T_RP : T_REF_RAS),
    localparam int CW  = $clog2(TMAX + 1),
    localparam int RCW = $clog2(T_RAS_MAX + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  host_req_t         req_in,
    input  logic              row_hit,
    input  logic              ref_pend,
    output logic              ref_ack,
    output host_req_t         cur,
    output logic              sel_col,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ras_n,
    output logic              lcas_n,
    output logic              ucas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [LANES-1:0]  dq_oe
);
    seq_state_t      state;
    logic [CW-1:0]   cnt;
    logic [RCW-1:0]  ras_cnt;
    logic            ras_limit;
    logic            accept;
    logic            in_cas;
    logic            in_ref;
    logic            wr_phase;

    assign ras_limit = (ras_cnt >= RCW'(T_RAS_MAX));
    assign req_ready = !ref_pend &&
                       ((state == ST_IDLE) ||
                        ((state == ST_PAGE) && !ras_limit && row_hit));
    assign accept    = req_valid && req_ready;
    assign ref_ack   = (state == ST_IDLE) && ref_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            ras_cnt  <= '0;
            cur      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (state == ST_ROW) begin
                ras_cnt <= '0;
            end else if (row_open(state) && ras_cnt != '1) begin
                ras_cnt <= ras_cnt + RCW'(1);
            end
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (ref_pend) begin
                        state <= ST_RCAS;
                    end else if (accept) begin
                        cur   <= req_in;
                        state <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    cnt   <= '0;
                    state <= ST_RAS;
                end
                ST_RAS: begin
                    if (cnt == CW'(T_RCD - 1)) begin
                        cnt   <= '0;
                        state <= ST_COL;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_COL: begin
                    cnt   <= '0;
                    state <= ST_CAS;
                end
                ST_CAS: begin
                    if (cnt == CW'(T_CAS - 1)) begin
                        cnt   <= '0;
                        state <= ST_PAGE;
                        if (!cur.we) begin
                            rd_valid <= 1'b1;
                            rd_data  <= dq_in;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_PAGE: begin
                    cnt <= '0;
                    if (accept) begin
                        cur   <= req_in;
                        state <= ST_COL;
                    end else if (ref_pend || ras_limit || req_valid) begin
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (cnt == CW'(T_RP - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RCAS: begin
                    cnt   <= '0;
                    state <= ST_RREF;
                end
                ST_RREF: begin
                    if (cnt == CW'(T_REF_RAS - 1)) begin
                        cnt   <= '0;
                        state <= ST_PRE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        in_cas   = (state == ST_CAS);
        in_ref   = (state == ST_RCAS) || (state == ST_RREF);
        wr_phase = cur.we && ((state == ST_COL) || (state == ST_CAS));
        ras_n    = !(row_open(state) || (state == ST_RREF));
        lcas_n   = !((in_cas && cur.be[0]) || in_ref);
        ucas_n   = !((in_cas && cur.be[1]) || in_ref);
        we_n     = !wr_phase;
        oe_n     = !(in_cas && !cur.we);
        dq_oe    = wr_phase ? cur.be : '0;
        sel_col  = (state == ST_COL) || in_cas;
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int GEOM         = 0,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int T_REF_RAS    = 3,
    parameter int T_RAS_MAX    = 40,
    parameter int REF_INTERVAL = 780,
    localparam int ROW_W = row_w(GEOM),
    localparam int COL_W = col_w(GEOM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [LANES-1:0]   req_be,
    input  logic [WORD_AW-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               dram_ras_n,
    output logic               dram_lcas_n,
    output logic               dram_ucas_n,
    output logic               dram_we_n,
    output logic               dram_oe_n,
    output logic [ROW_W-1:0]   dram_addr,
    output logic [DATA_W-1:0]  dram_dq_out,
    output logic [LANES-1:0]   dram_dq_oe,
    input  logic [DATA_W-1:0]  dram_dq_in
);
    host_req_t req_in;
    host_req_t cur;
    logic      ref_pend;
    logic      ref_ack;
    logic      row_hit;
    logic      sel_col;

    assign req_in      = '{we: req_we, be: req_be, addr: req_addr, wdata: req_wdata};
    assign dram_dq_out = cur.wdata;

    edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    edo_addr_mux #(.GEOM(GEOM)) i_mux (
        .open_addr (cur.addr),
        .next_row  (req_addr[WORD_AW-1:COL_W]),
        .sel_col   (sel_col),
        .pin_addr  (dram_addr),
        .row_hit   (row_hit)
    );

    edo_seq #(
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_RP      (T_RP),
        .T_REF_RAS (T_REF_RAS),
        .T_RAS_MAX (T_RAS_MAX)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_in    (req_in),
        .row_hit   (row_hit),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .cur       (cur),
        .sel_col   (sel_col),
        .dq_in     (dram_dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ras_n     (dram_ras_n),
        .lcas_n    (dram_lcas_n),
        .ucas_n    (dram_ucas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .dq_oe     (dram_dq_oe)
    );
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       ras_n,
    input logic       lcas_n,
    input logic       ucas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic [1:0] dq_oe,
    input logic       ref_pend
);
    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !lcas_n) |-> ($past(!lcas_n && !ucas_n) && !ucas_n && we_n));

    // R5
    early_we_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n && ($fell(lcas_n) || $fell(ucas_n))) |-> $past(!we_n));

    // R4
    read_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (we_n && !ras_n && !(lcas_n && ucas_n)));

    // R1
    standby_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n && lcas_n && ucas_n) |-> (dq_oe == 2'b00 && oe_n && we_n));

    // R9
    ref_block_chk: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

    // R11
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R3
    lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && ucas_n && !lcas_n) |-> !dq_oe[1]);
endmodule

bind edo_dram_ctrl edo_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .ras_n     (dram_ras_n),
    .lcas_n    (dram_lcas_n),
    .ucas_n    (dram_ucas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_oe     (dram_dq_oe),
    .ref_pend  (ref_pend)
);

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_REF_RAS = 3;
    localparam int T_RAS_MAX = 60, REF_INTERVAL = 150;
    localparam int ROW_W = 13, COL_W = 9;

    typedef struct packed {
        logic        we;
        logic [21:0] addr;
        logic [1:0]  be;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b1, 22'h0A0010, 2'b11, 16'hBEEF, 16'hBEEF},
        '{1'b1, 22'h0A0011, 2'b11, 16'h1234, 16'h1234},
        '{1'b0, 22'h0A0010, 2'b11, 16'h0000, 16'hBEEF},
        '{1'b1, 22'h0A0010, 2'b01, 16'h7755, 16'hBE55},
        '{1'b1, 22'h0A0011, 2'b10, 16'hAA99, 16'hAA34},
        '{1'b0, 22'h0A0010, 2'b11, 16'h0000, 16'hBE55},
        '{1'b0, 22'h0A0011, 2'b11, 16'h0000, 16'hAA34},
        '{1'b1, 22'h3FFFFF, 2'b11, 16'hF00D, 16'hF00D},
        '{1'b1, 22'h000000, 2'b11, 16'h0FF0, 16'h0FF0},
        '{1'b0, 22'h3FFFFF, 2'b11, 16'h0000, 16'hF00D},
        '{1'b0, 22'h000000, 2'b11, 16'h0000, 16'h0FF0},
        '{1'b0, 22'h0A0011, 2'b01, 16'h0000, 16'h0034}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [1:0]        req_be = 2'b00;
    logic [21:0]       req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic              rd_valid;
    logic [15:0]       rd_data;
    logic              dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n;
    logic [ROW_W-1:0]  dram_addr;
    logic [15:0]       dram_dq_out;
    logic [1:0]        dram_dq_oe;
    logic [15:0]       dq_in_m = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    edo_dram_ctrl #(
        .GEOM(0), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS),
        .T_RAS_MAX(T_RAS_MAX), .REF_INTERVAL(REF_INTERVAL)
    ) i_edo_dram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_m)
    );

    // memory model: watches strobes on falling clock edges
    logic [15:0] mem [int];
    logic        p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
    logic [ROW_W-1:0] m_row = '0;
    int m_key = 0;
    int cyc = 0, ref_cnt = 0, acc_falls = 0, wr_events = 0, rd_pulses = 0;
    int cbr_bad = 0, ew_bad = 0;
    int low_run = 0, high_run = 0, max_low = 0, min_high = 1000000;
    int last_ref = -1, max_gap = 0;

    function automatic logic [15:0] mem_rd(input int k);
        return mem.exists(k) ? mem[k] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (rd_valid) rd_pulses++;
            if (p_ras && !dram_ras_n) begin
                if (!dram_lcas_n || !dram_ucas_n) begin
                    ref_cnt++;
                    if (dram_lcas_n || dram_ucas_n || p_l || p_u || !dram_we_n) cbr_bad++;
                    if (last_ref >= 0 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                    last_ref = cyc;
                end else begin
                    acc_falls++;
                    m_row = dram_addr;
                    if (high_run < min_high) min_high = high_run;
                end
                low_run = 0;
            end
            if (!p_ras && dram_ras_n) begin
                if (low_run > max_low) max_low = low_run;
                high_run = 0;
            end
            if (!dram_ras_n) low_run++; else high_run++;
            if (!dram_ras_n && !p_ras && ((p_l && !dram_lcas_n) || (p_u && !dram_ucas_n))) begin
                m_key = int'({m_row, dram_addr[COL_W-1:0]});
                if (!dram_we_n) begin
                    logic [15:0] w;
                    w = mem_rd(m_key);
                    if (p_we) ew_bad++;
                    if (!dram_lcas_n) begin
                        if (!dram_dq_oe[0]) ew_bad++;
                        w[7:0] = dram_dq_out[7:0];
                    end
                    if (!dram_ucas_n) begin
                        if (!dram_dq_oe[1]) ew_bad++;
                        w[15:8] = dram_dq_out[15:8];
                    end
                    mem[m_key] = w;
                    wr_events++;
                end
            end
            if (!dram_ras_n && !dram_oe_n && (!dram_lcas_n || !dram_ucas_n))
                dq_in_m = {dram_ucas_n ? 8'h00 : mem_rd(m_key)[15:8],
                           dram_lcas_n ? 8'h00 : mem_rd(m_key)[7:0]};
            else
                dq_in_m = 16'h0000;
            p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // returns read data (or 0 for writes); waits for the access to complete
    task automatic do_op(input logic we, input logic [21:0] a, input logic [1:0] be,
                         input logic [15:0] wd, output logic [15:0] rdat);
        int wr0;
        int guard;
        wr0 = wr_events;
        rdat = '0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
        #1;
        guard = 0;
        while (!req_ready && guard < 1000) begin
            @(negedge clk); #1; guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        if (we) begin
            while (wr_events == wr0 && guard < 100) begin @(negedge clk); guard++; end
        end else begin
            while (!rd_valid && guard < 100) begin @(negedge clk); guard++; end
            rdat = rd_data;
        end
        check(guard < 100, "R11", guard, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] mask;
        int f0, r0, reads;
        logic [ROW_W-1:0] prev_row;
        bit have_prev;
        have_prev = 0;
        reads = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_oe_n && dram_we_n && dram_dq_oe == 2'b00,
              "R1", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_oe_n, dram_we_n}, 5'h1F);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_dq_oe == 2'b00, "R1",
              {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'h7);

        foreach (VEC[i]) begin
            f0 = acc_falls; r0 = ref_cnt;
            do_op(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wdata, rd);
            mask = {{8{VEC[i].be[1]}}, {8{VEC[i].be[0]}}};
            if (VEC[i].we) begin
                // R2 and R3: stored at the pin-decoded row/column with only enabled lanes
                check(mem_rd(int'(VEC[i].addr)) == VEC[i].exp, "R2/R3 write",
                      mem_rd(int'(VEC[i].addr)), VEC[i].exp);
            end else begin
                reads++;
                // R4 read data on enabled lanes
                check((rd & mask) == (VEC[i].exp & mask), "R4 read", rd & mask, VEC[i].exp & mask);
            end
            if (have_prev && ref_cnt == r0) begin
                if (prev_row == VEC[i].addr[21:COL_W])
                    check(acc_falls == f0, "R6 page hit", acc_falls - f0, 0);
                else
                    check(acc_falls == f0 + 1, "R7 row change", acc_falls - f0, 1);
            end
            prev_row = VEC[i].addr[21:COL_W];
            have_prev = 1;
        end

        // R5: write strobes ordered, lanes driven
        check(ew_bad == 0, "R5", ew_bad, 0);
        // R7: precharge width before every access RAS fall
        check(min_high >= T_RP, "R7 precharge", min_high, T_RP);

        // R10: long same-row burst must reopen the row
        f0 = acc_falls;
        for (int k = 0; k < 24; k++) begin
            do_op(1'b0, 22'h0A0000 + 22'(k), 2'b11, 16'h0, rd);
            reads++;
            if (k == 16) check(rd == 16'hBE55, "R6 burst data", rd, 16'hBE55);
        end
        check(acc_falls - f0 >= 2, "R10 reopen", acc_falls - f0, 2);
        check(max_low <= T_RAS_MAX + T_CAS + 3, "R10 max low", max_low, T_RAS_MAX + T_CAS + 3);

        // R11: one pulse per read
        repeat (5) @(negedge clk);
        check(rd_pulses == reads, "R11 pulses", rd_pulses, reads);

        // R8: idle refresh rate and ordering
        r0 = ref_cnt;
        repeat (1500) @(negedge clk);
        check((ref_cnt - r0) >= 9 && (ref_cnt - r0) <= 11, "R8 rate", ref_cnt - r0, 10);
        check(cbr_bad == 0, "R8 order", cbr_bad, 0);
        check(dram_ras_n || !dram_lcas_n, "R1 idle", dram_ras_n, 1);

        // R9: refresh never starved by host traffic
        check(max_gap <= REF_INTERVAL + T_RAS_MAX + T_CAS + T_RP + 8, "R9 gap",
              max_gap, REF_INTERVAL + T_RAS_MAX + T_CAS + T_RP + 8);

        finish_run();
    end
endmodule